// File: doc/BRIEF.md
# Cache Block Refill Memory Controller

This block fetches a four-word cache block from a slow backing store after a cache miss. It accepts one request at a time, each carrying a word address and an organisation code. For that request it plays out the bus timeline of one of three backing-store layouts, then hands the words back with a per-word strobe. The three layouts are a single one-word-wide memory, a memory one block wide, and four word-interleaved banks.

Every layout follows the same sequence. One bus cycle carries the address. Each store access then takes fifteen bus cycles before its data is ready, and each word transfer takes one bus cycle. The layouts differ in how accesses and transfers overlap, so each gives a different miss penalty. The block counts the bus cycles from the address phase to the last transfer and presents that count on an output, so a cache designer can compare the three layouts on the same traffic. The backing store is modelled inside the block: the data it returns is a fixed function of the word address.

Cycle numbering used below: the request is accepted on a rising edge, and bus cycle k is the k-th clock cycle after that edge. Bus cycle 1 is the address phase.

Top module: `refill_ctrl`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request is taken on an edge where `req_valid` and `req_ready` are both high. A request held on `req_valid` while busy is not taken and does not disturb the refill in progress. It is taken on the first edge after `done`.
- R2: After a request is taken, `req_ready` stays low through every bus cycle up to and including the `done` cycle. No word strobe is raised during bus cycles 1 to 16, which are the address phase plus fifteen access cycles.
- R3: With organisation code 0 (one-word-wide memory), word i is strobed alone in bus cycle 17+16·i. `done` comes in bus cycle 66 and `penalty` reads 65.
- R4: With organisation code 1 (block-wide memory), all four strobe bits are high together in bus cycle 17 only. `done` comes in bus cycle 18 and `penalty` reads 17.
- R5: With organisation code 2 (four interleaved banks), word i is strobed alone in bus cycle 17+i. `done` comes in bus cycle 21 and `penalty` reads 20.
- R6: Organisation code 3 behaves exactly as code 0.
- R7: Bit i of `rsp_mask` marks word offset i. Its data is on `rsp_data[32·i +: 32]` and equals (aligned word address + i) XOR 32'h5A3C_0000.
- R8: The two low bits of `req_addr` select nothing. The block is always fetched from the address with those bits cleared, starting at offset 0 and rising in offset order.
- R9: `done` is a single-cycle pulse in the cycle after the last transfer. `penalty` holds its value until the next `done`. After reset, `req_ready` is 1 while `done`, `rsp_mask` and `penalty` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Controller idle, request taken this edge |
| req_addr | input | 32 | Word address of the missing block |
| req_org | input | 2 | Organisation: 0 one-word-wide, 1 block-wide, 2 interleaved, 3 as 0 |
| rsp_mask | output | 4 | Per-word transfer strobe, bit i = offset i |
| rsp_data | output | 128 | Word data, offset i in bits 32·i+31 down to 32·i |
| done | output | 1 | Refill complete pulse |
| penalty | output | 8 | Measured refill penalty in bus cycles |

## Verification
Each organisation code, including the reserved one, is run against several addresses. The addresses include ones with non-zero low bits and one at the top of the address space. The bench compares every bus cycle's strobe and data with a timeline it computes itself. This separates serialised accesses (16-cycle spacing), overlapped bank accesses (one-cycle spacing) and a single wide transfer, and it shows whether the offset bits are dropped. A request held on the input during a refill checks that backpressure neither drops the held request nor shifts the timing of the refill in progress.

// File: rtl/refill_pkg.sv
package refill_pkg;

    typedef enum logic [1:0] {
        ORG_NARROW = 2'd0,
        ORG_WIDE   = 2'd1,
        ORG_BANKED = 2'd2,
        ORG_RSVD   = 2'd3
    } org_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WAIT,
        ST_DONE
    } st_e;

    // The reserved code falls back to the one-word-wide layout
    function automatic org_e org_decode(input logic [1:0] code);
        return (code == 2'd3) ? ORG_NARROW : org_e'(code);
    endfunction

    // Refill penalty in bus cycles for a layout
    function automatic int unsigned penalty_of(input org_e o,
                                               input int unsigned lat,
                                               input int unsigned words);
        case (o)
            ORG_WIDE:   return 1 + lat + 1;
            ORG_BANKED: return 1 + lat + words;
            default:    return 1 + words * (lat + 1);
        endcase
    endfunction

endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LAT = 15,
    parameter logic [DW-1:0] SALT = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          take,
    input  logic [AW-1:0] waddr,
    output logic          rdy,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;
    logic          pend;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            pend   <= 1'b0;
            data_q <= '0;
        end else if (start) begin
            cnt    <= CW'(LAT);
            pend   <= 1'b1;
            data_q <= DW'(waddr) ^ SALT;
        end else begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            if (take) pend <= 1'b0;
        end
    end

    assign rdy  = pend && (cnt == '0);
    assign data = data_q;

    // R2
    bank_latency_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !rdy);
    // R2
    bank_take_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> rdy);

endmodule

// File: rtl/refill_seq.sv
module refill_seq
    import refill_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int AW = 32,
    localparam int IW = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [1:0]       req_org,
    input  logic [AW-1:0]    req_addr,
    input  logic [WORDS-1:0] bank_rdy,
    output logic             req_ready,
    output logic             accept,
    output logic [WORDS-1:0] start_mask,
    output logic [WORDS-1:0] take_mask,
    output logic [WORDS-1:0] rsp_mask,
    output logic [IW-1:0]    start_word,
    output logic [AW-1:0]    base_addr,
    output org_e             org_cur,
    output logic             busy,
    output logic             last_xfer,
    output logic             done
);
    localparam logic [IW-1:0] LAST = IW'(WORDS - 1);

    st_e           st;
    org_e          org_q;
    logic [IW-1:0] widx;
    logic [AW-1:0] base_q;
    logic          fire;

    assign req_ready = (st == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign busy      = (st == ST_ADDR) || (st == ST_WAIT);
    assign done      = (st == ST_DONE);
    assign org_cur   = org_q;
    assign base_addr = base_q;

    always_comb begin
        case (org_q)
            ORG_WIDE:   fire = &bank_rdy;
            ORG_BANKED: fire = bank_rdy[widx];
            default:    fire = bank_rdy[0];
        endcase
    end

    always_comb begin
        start_mask = '0;
        take_mask  = '0;
        rsp_mask   = '0;
        last_xfer  = 1'b0;
        start_word = (st == ST_ADDR) ? '0 : widx + 1'b1;
        if (st == ST_ADDR) begin
            start_mask = (org_q == ORG_NARROW) ? WORDS'(1) : '1;
        end else if (st == ST_WAIT && fire) begin
            last_xfer = (org_q == ORG_WIDE) || (widx == LAST);
            case (org_q)
                ORG_WIDE: begin
                    take_mask = '1;
                    rsp_mask  = '1;
                end
                ORG_BANKED: begin
                    take_mask[widx] = 1'b1;
                    rsp_mask[widx]  = 1'b1;
                end
                default: begin
                    take_mask[0]   = 1'b1;
                    rsp_mask[widx] = 1'b1;
                    if (widx != LAST) start_mask[0] = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            org_q  <= ORG_NARROW;
            widx   <= '0;
            base_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (accept) begin
                    st     <= ST_ADDR;
                    org_q  <= org_decode(req_org);
                    widx   <= '0;
                    base_q <= {req_addr[AW-1:IW], {IW{1'b0}}};
                end
                ST_ADDR: st <= ST_WAIT;
                ST_WAIT: if (fire) begin
                    widx <= widx + 1'b1;
                    if (last_xfer) st <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !req_ready));
    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);
    // R2
    addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ADDR) |-> (rsp_mask == '0));

endmodule

// File: rtl/refill_meter.sv
module refill_meter #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          busy,
    input  logic          last_xfer,
    output logic [PW-1:0] penalty
);
    logic [PW-1:0] cyc;
    logic [PW-1:0] pen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc   <= '0;
            pen_q <= '0;
        end else begin
            if (accept)    cyc <= PW'(1);
            else if (busy) cyc <= cyc + 1'b1;
            if (last_xfer) pen_q <= cyc;
        end
    end

    assign penalty = pen_q;

    // R9
    pen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !last_xfer |=> $stable(pen_q));
    // R2
    xfer_busy_chk: assert property (@(posedge clk) disable iff (rst)
        last_xfer |-> busy);

endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
    import refill_pkg::*;
#(
    parameter int WORDS = 4,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int LAT = 15,
    parameter int PW = 8,
    parameter logic [DW-1:0] SALT = 32'h5A3C_0000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [AW-1:0]       req_addr,
    input  logic [1:0]          req_org,
    output logic [WORDS-1:0]    rsp_mask,
    output logic [WORDS*DW-1:0] rsp_data,
    output logic                done,
    output logic [PW-1:0]       penalty
);
    localparam int IW = $clog2(WORDS);

    logic             accept;
    logic             busy;
    logic             last_xfer;
    logic [WORDS-1:0] start_mask;
    logic [WORDS-1:0] take_mask;
    logic [WORDS-1:0] bank_rdy;
    logic [IW-1:0]    start_word;
    logic [AW-1:0]    base_addr;
    org_e             org_cur;
    logic [DW-1:0]    bank_data [WORDS];

    refill_seq #(.WORDS(WORDS), .AW(AW)) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_org(req_org), .req_addr(req_addr),
        .bank_rdy(bank_rdy), .req_ready(req_ready), .accept(accept),
        .start_mask(start_mask), .take_mask(take_mask), .rsp_mask(rsp_mask),
        .start_word(start_word), .base_addr(base_addr), .org_cur(org_cur),
        .busy(busy), .last_xfer(last_xfer), .done(done)
    );

    refill_meter #(.PW(PW)) u_meter (
        .clk(clk), .rst(rst), .accept(accept), .busy(busy),
        .last_xfer(last_xfer), .penalty(penalty)
    );

    for (genvar i = 0; i < WORDS; i++) begin : g_bank
        logic [AW-1:0] waddr;
        if (i == 0) begin : g_first
            assign waddr = {base_addr[AW-1:IW], start_word};
        end else begin : g_rest
            assign waddr = {base_addr[AW-1:IW], IW'(i)};
        end

        refill_bank #(.AW(AW), .DW(DW), .LAT(LAT), .SALT(SALT)) u_bank (
            .clk(clk), .rst(rst),
            .start(start_mask[i]), .take(take_mask[i]), .waddr(waddr),
            .rdy(bank_rdy[i]), .data(bank_data[i])
        );

        assign rsp_data[i*DW +: DW] =
            (org_cur == ORG_NARROW) ? bank_data[0] : bank_data[i];
    end

    // R3
    penalty_value_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (penalty == PW'(penalty_of(org_cur, LAT, WORDS))));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R10
    mask_shape_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_mask) || (rsp_mask == '1));
    // R1
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_mask != '0) |-> !req_ready);

endmodule

// File: tb/sim_refill_ctrl.sv
`timescale 1ns/1ps
module sim_refill_ctrl;
    localparam int LATC = 15;
    localparam logic [31:0] SALTC = 32'h5A3C_0000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [1:0]   req_org = '0;
    logic [3:0]   rsp_mask;
    logic [127:0] rsp_data;
    logic         done;
    logic [7:0]   penalty;

    int total = 0;
    int bad = 0;
    int prev_n = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    refill_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_org(req_org), .rsp_mask(rsp_mask),
        .rsp_data(rsp_data), .done(done), .penalty(penalty)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pen_of(input logic [1:0] org);
        case (org)
            2'd1:    return 1 + LATC + 1;
            2'd2:    return 1 + LATC + 4;
            default: return 1 + 4 * (LATC + 1);
        endcase
    endfunction

    function automatic logic [3:0] exp_mask(input logic [1:0] org, input int k);
        int first;
        first = 2 + LATC;
        case (org)
            2'd1: return (k == first) ? 4'hF : 4'h0;
            2'd2: return (k >= first && k < first + 4) ? 4'(1 << (k - first)) : 4'h0;
            default: begin
                if (k >= first && (k - first) % (LATC + 1) == 0 && (k - first) / (LATC + 1) < 4)
                    return 4'(1 << ((k - first) / (LATC + 1)));
                return 4'h0;
            end
        endcase
    endfunction

    // Runs one refill; optionally holds a next request on the input while busy
    task automatic run_txn(input logic [1:0] org, input logic [31:0] addr,
                           input bit hold, input logic [1:0] norg,
                           input logic [31:0] naddr, input string rtag);
        int n;
        int tl_bad;
        int dat_bad;
        int rdy_bad;
        int done_k;
        logic [3:0] first_act;
        logic [3:0] first_exp;
        logic [31:0] base;
        n = pen_of(org);
        base = {addr[31:2], 2'b00};
        tl_bad = 0; dat_bad = 0; rdy_bad = 0; done_k = -1;
        first_act = '0; first_exp = '0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready when idle", req_ready, 1);
        if (prev_n != 0)
            check(penalty == 8'(prev_n), "R9", "penalty held", penalty, prev_n);
        req_valid = 1'b1;
        req_addr  = addr;
        req_org   = org;
        @(posedge clk);
        for (int k = 1; k <= n + 1; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (hold) begin
                    req_addr = naddr;
                    req_org  = norg;
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (rsp_mask != exp_mask(org, k)) begin
                if (tl_bad == 0) begin
                    first_act = rsp_mask;
                    first_exp = exp_mask(org, k);
                end
                tl_bad++;
            end
            for (int i = 0; i < 4; i++)
                if (rsp_mask[i] && rsp_data[i*32 +: 32] != ((base + 32'(i)) ^ SALTC))
                    dat_bad++;
            if (req_ready) rdy_bad++;
            if (done && done_k < 0) done_k = k;
            else if (done) done_k = 999;
        end
        check(tl_bad == 0, rtag, "strobe timeline first mask", first_act, first_exp);
        check(dat_bad == 0, "R7 R8", "word data mismatches", dat_bad, 0);
        check(rdy_bad == 0, "R2", "ready low while busy", rdy_bad, 0);
        check(done_k == n + 1, "R9", "done cycle", done_k, n + 1);
        check(penalty == 8'(n), rtag, "penalty", penalty, n);
        prev_n = n;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] addrs [4];
        addrs[0] = 32'h0000_0000;
        addrs[1] = 32'h0000_0123;
        addrs[2] = 32'hFFFF_FFFC;
        addrs[3] = 32'h1234_5679;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
        check(done == 1'b0, "R9", "reset done", done, 0);
        check(rsp_mask == 4'h0, "R9", "reset mask", rsp_mask, 0);
        check(penalty == 8'h0, "R9", "reset penalty", penalty, 0);

        for (int a = 0; a < 4; a++) begin
            run_txn(2'd0, addrs[a], 1'b0, 2'd0, 32'h0, "R3");
            run_txn(2'd1, addrs[a], 1'b0, 2'd0, 32'h0, "R4");
            run_txn(2'd2, addrs[a], 1'b0, 2'd0, 32'h0, "R5");
            run_txn(2'd3, addrs[a], 1'b0, 2'd0, 32'h0, "R6");
        end

        // R1: held request during a refill, then served afterwards
        run_txn(2'd2, 32'h0000_0A40, 1'b1, 2'd1, 32'h0000_0B83, "R5");
        run_txn(2'd1, 32'h0000_0B83, 1'b1, 2'd0, 32'h0000_0C07, "R1");
        run_txn(2'd0, 32'h0000_0C07, 1'b0, 2'd0, 32'h0, "R1");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule